// File: doc/BRIEF.md
# Clocked Word-Sync Serial Receiver

This block takes three serial lines that have already been turned into logic levels: a bit clock from the sender, a serial data line and a word-sync gate. All three lines pass through two-flop synchronisers into the system clock domain. Data is captured on each rising edge of the incoming bit clock. The sync gate marks where each 32-bit word begins and ends. It is high across the whole word except for a short low gap in the second half of bit 8. That gap separates the 8-bit label from the 24 data bits.

The receiver checks the shape of the sync gate as it assembles each word. A correct word is presented on a 32-bit output with a one-cycle valid strobe. The first bit received sits in the most significant position. A malformed word is discarded and a one-cycle frame-error pulse is raised. The receiver then ignores the line until the sync gate has been seen low again.

A separate watchdog counts system cycles since the last edge of either polarity on the bit clock. It raises a clock-lost flag when that count reaches a limit. The default limit matches 320 µs at 250 MHz. A stalled clock does not abort a word in progress.

Top module: `wordsync_rx`

## Requirements
- R1: After synchronous reset, `word_o` is zero and `word_valid_o`, `frame_err_o` and `clk_lost_o` are low.
- R2: A word is accepted when the following all hold: the sync gate is high at 32 rising bit-clock edges; it has one low interval between the 8th and 9th of those edges, with no rising edge inside that interval; and it falls after the 32nd edge and before a 33rd. The word then appears on `word_o` with the first sampled bit in bit 31 and the last in bit 0. `word_valid_o` pulses for exactly one cycle, and `word_o` changes only in that cycle.
- R3: Data is sampled only at rising edges of the bit clock. Changes on the data line at any other time, including while the clock is high, do not alter the word.
- R4: If the sync gate has not been low between the 8th and 9th rising edges, a frame error is raised at the 9th rising edge. No word is delivered.
- R5: If the sync gate goes low while fewer than 32 bits have been taken, other than the bit-8 gap, a frame error is raised. No word is delivered.
- R6: A rising bit-clock edge while the sync gate is still high after 32 bits raises a frame error. No word is delivered.
- R7: After a frame error or a delivered word, a new word starts only on a rising edge that comes after the sync gate has been seen low. Clocking with the sync gate high and no low seen in between starts nothing.
- R8: `clk_lost_o` goes high once `WD_LIMIT` system cycles pass with no bit-clock edge of either polarity. It stays high until the next edge, and clears in the cycle after that edge is seen.
- R9: `frame_err_o` is a single-cycle pulse and is never high together with `word_valid_o`.
- R10: Each serial line has a fixed latency through a two-flop synchroniser. An output responds in the third system clock after the input change that caused it.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock from the sender |
| bdata_i | input | 1 | Serial data line |
| bsync_i | input | 1 | Word-sync gate |
| word_o | output | WORD_BITS | Last accepted word, first bit in the MSB |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| frame_err_o | output | 1 | One-cycle pulse for a malformed word |
| clk_lost_o | output | 1 | Bit clock has shown no edge for WD_LIMIT cycles |

## Verification
The clock-lost watchdog and the framing check can act in the same cycle. One bit-clock edge can clear `clk_lost_o` and also count as the 33rd rising edge of a word. To provoke this, the bench sends 32 bits and then holds the bit clock still with the sync gate high until the flag rises. It then releases the clock. The bench expects the frame-error pulse and the flag drop to land together in the one cycle that its reference model predicts.

// File: rtl/wordsync_rx_pkg.sv
package wordsync_rx_pkg;

    // One sample of the three serial lines
    typedef struct packed {
        logic clk;
        logic data;
        logic sync;
    } line_s;

    localparam int LINE_W = $bits(line_s);

    typedef enum logic [0:0] {
        FR_IDLE = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_e;

    // Counter width able to hold the value n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wordsync_rx_line_sync.sv
module wordsync_rx_line_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    for (genvar g = 0; g < W; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= 1'b0;
                stab_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= raw_i[g];
                stab_q[g] <= meta_q[g];
            end
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/wordsync_rx_edge_det.sv
module wordsync_rx_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o,
    output logic any_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign any_o  = lvl_i ^ prev_q;
endmodule

// File: rtl/wordsync_rx_framer.sv
module wordsync_rx_framer
    import wordsync_rx_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int GAP_BIT   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rise_i,
    input  logic                 data_i,
    input  logic                 sync_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 valid_o,
    output logic                 err_o
);
    localparam int CW = cnt_width(WORD_BITS);
    localparam logic [CW-1:0] GAP_AT  = CW'(GAP_BIT);
    localparam logic [CW-1:0] LAST_AT = CW'(WORD_BITS);

    fr_state_e            state_q;
    logic                 armed_q;
    logic                 gap_q;
    logic [CW-1:0]        cnt_q;
    logic [WORD_BITS-1:0] shift_q;
    logic [WORD_BITS-1:0] word_q;
    logic                 valid_q;
    logic                 err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
            armed_q <= 1'b0;
            gap_q   <= 1'b0;
            cnt_q   <= '0;
            shift_q <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            case (state_q)
                FR_IDLE: begin
                    if (!sync_i) begin
                        armed_q <= 1'b1;
                    end else if (armed_q && rise_i) begin
                        shift_q <= {shift_q[WORD_BITS-2:0], data_i};
                        cnt_q   <= CW'(1);
                        gap_q   <= 1'b0;
                        armed_q <= 1'b0;
                        state_q <= FR_RUN;
                    end
                end
                default: begin
                    if (!sync_i) begin
                        if (cnt_q == GAP_AT && !rise_i) begin
                            gap_q <= 1'b1;
                        end else if (cnt_q == LAST_AT) begin
                            word_q  <= shift_q;
                            valid_q <= 1'b1;
                            state_q <= FR_IDLE;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= FR_IDLE;
                        end
                    end else if (rise_i) begin
                        if (cnt_q == LAST_AT || (cnt_q == GAP_AT && !gap_q)) begin
                            err_q   <= 1'b1;
                            state_q <= FR_IDLE;
                        end else begin
                            shift_q <= {shift_q[WORD_BITS-2:0], data_i};
                            cnt_q   <= cnt_q + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

    // R9
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && err_o));

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (word_o != $past(word_o)) |-> valid_o);
endmodule

// File: rtl/wordsync_rx_clk_watchdog.sv
module wordsync_rx_clk_watchdog
    import wordsync_rx_pkg::*;
#(
    parameter int WD_LIMIT = 80000
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    output logic lost_o
);
    localparam int WW = cnt_width(WD_LIMIT);
    localparam logic [WW-1:0] LIM = WW'(WD_LIMIT);

    logic [WW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst)              idle_q <= '0;
        else if (edge_i)      idle_q <= '0;
        else if (idle_q != LIM) idle_q <= idle_q + WW'(1);
    end

    assign lost_o = (idle_q == LIM);

    // R8
    edge_clears_chk: assert property (@(posedge clk) disable iff (rst)
        edge_i |=> !lost_o);

    // R8
    lost_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lost_o && !edge_i) |=> lost_o);
endmodule

// File: rtl/wordsync_rx.sv
module wordsync_rx
    import wordsync_rx_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int GAP_BIT   = 8,
    parameter int WD_LIMIT  = 80000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk_i,
    input  logic                 bdata_i,
    input  logic                 bsync_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_valid_o,
    output logic                 frame_err_o,
    output logic                 clk_lost_o
);
    line_s raw;
    line_s lines;
    logic [LINE_W-1:0] lines_vec;
    logic bclk_rise;
    logic bclk_edge;

    assign raw = '{clk: bclk_i, data: bdata_i, sync: bsync_i};

    wordsync_rx_line_sync #(.W(LINE_W)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw),
        .sync_o (lines_vec)
    );

    assign lines = line_s'(lines_vec);

    wordsync_rx_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lines.clk),
        .rise_o (bclk_rise),
        .any_o  (bclk_edge)
    );

    wordsync_rx_framer #(
        .WORD_BITS (WORD_BITS),
        .GAP_BIT   (GAP_BIT)
    ) u_framer (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (bclk_rise),
        .data_i  (lines.data),
        .sync_i  (lines.sync),
        .word_o  (word_o),
        .valid_o (word_valid_o),
        .err_o   (frame_err_o)
    );

    wordsync_rx_clk_watchdog #(.WD_LIMIT(WD_LIMIT)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .edge_i (bclk_edge),
        .lost_o (clk_lost_o)
    );
endmodule

// File: tb/wordsync_rx_test.sv
`timescale 1ns/1ps
module wordsync_rx_test;
    localparam int WDL = 200;
    localparam int H   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0, bdata = 1'b0, bsync = 1'b0;
    logic [31:0] word;
    logic valid, ferr, lost;

    int checks = 0;
    int fails  = 0;
    int n_valid = 0;
    int n_err   = 0;
    logic [31:0] last_word = '0;

    always #2 clk = ~clk;

    wordsync_rx #(.WORD_BITS(32), .GAP_BIT(8), .WD_LIMIT(WDL)) uut (
        .clk(clk), .rst(rst), .bclk_i(bclk), .bdata_i(bdata), .bsync_i(bsync),
        .word_o(word), .word_valid_o(valid), .frame_err_o(ferr), .clk_lost_o(lost)
    );

    // Behavioural reference: history of raw samples, then a framing model
    bit hc[4], hd[4], hs[4];
    int m_run, m_armed, m_cnt, m_gap, m_wd;
    logic [31:0] m_bits, e_word;
    bit e_valid, e_err, e_lost;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin hc[i] = 0; hd[i] = 0; hs[i] = 0; end
            m_run = 0; m_armed = 0; m_cnt = 0; m_gap = 0; m_wd = 0;
            m_bits = '0; e_word = '0; e_valid = 0; e_err = 0; e_lost = 0;
        end else begin
            bit r, e, d, s;
            for (int i = 3; i > 0; i--) begin hc[i] = hc[i-1]; hd[i] = hd[i-1]; hs[i] = hs[i-1]; end
            hc[0] = bclk; hd[0] = bdata; hs[0] = bsync;
            r = hc[2] && !hc[3];
            e = hc[2] != hc[3];
            d = hd[2]; s = hs[2];
            e_valid = 0; e_err = 0;
            if (m_run == 0) begin
                if (!s) m_armed = 1;
                else if (m_armed == 1 && r) begin
                    m_bits = {m_bits[30:0], d}; m_cnt = 1; m_gap = 0; m_armed = 0; m_run = 1;
                end
            end else if (!s) begin
                if (m_cnt == 8 && !r) m_gap = 1;
                else if (m_cnt == 32) begin e_word = m_bits; e_valid = 1; m_run = 0; end
                else begin e_err = 1; m_run = 0; end
            end else if (r) begin
                if (m_cnt == 32 || (m_cnt == 8 && m_gap == 0)) begin e_err = 1; m_run = 0; end
                else begin m_bits = {m_bits[30:0], d}; m_cnt++; end
            end
            if (e) m_wd = 0; else if (m_wd < WDL) m_wd++;
            e_lost = (m_wd == WDL);
        end
    end

    // Per-cycle comparison against the model (R10 timing), away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (valid !== e_valid || word !== e_word) begin
                fails++;
                $display("FAIL R2 cycle: valid=%0b word=%h expected valid=%0b word=%h", valid, word, e_valid, e_word);
            end else if (ferr !== e_err) begin
                fails++;
                $display("FAIL R9 cycle: frame_err=%0b expected %0b", ferr, e_err);
            end else if (lost !== e_lost) begin
                fails++;
                $display("FAIL R8 cycle: clk_lost=%0b expected %0b", lost, e_lost);
            end
            if (valid) begin n_valid++; last_word = word; end
            if (ferr) n_err++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input bit s_lo, input bit s_hi0, input bit s_hi, input bit glitch);
        bclk = 1'b0; bdata = b; bsync = s_lo;
        wait_n(H);
        bclk = 1'b1; bsync = s_hi0;
        wait_n(1);
        bsync = s_hi;
        if (glitch) bdata = ~b;
        wait_n(H - 1);
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        bclk = 1'b0;
        wait_n(8);
    endtask

    // mode: 0 normal, 1 data glitch while clock high, 2 no bit-8 gap,
    //       3 sync drops at bit 20, 4 sync high over a 33rd edge, 5 stall then 33rd edge
    task automatic send_word(input logic [31:0] w, input int mode);
        for (int i = 1; i <= 32; i++) begin
            bit lo, hi;
            lo = !(mode == 3 && i >= 20);
            hi = lo;
            if (i == 8 && mode != 2) hi = 1'b0;
            send_bit(w[32-i], lo, lo, hi, mode == 1);
        end
        if (mode == 4) send_bit(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        if (mode == 5) begin
            bclk = 1'b0; bsync = 1'b1;
            wait_n(WDL + 20);
            check(lost == 1'b1, "R8 flag during stall", lost, 1);
            bclk = 1'b1;
            wait_n(H);
        end
        idle_bits(4);
    endtask

    task automatic clear_counts();
        n_valid = 0; n_err = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: bench did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(1);
        // R1
        check(word == 32'h0 && !valid && !ferr && !lost, "R1 reset state", {word[27:0], valid, ferr, lost}, 0);
        idle_bits(4);

        clear_counts();
        send_word(32'hA5C3_0F81, 0);
        check(n_valid == 1 && n_err == 0, "R2 good word count", n_valid, 1);
        check(last_word == 32'hA5C3_0F81, "R2 word value", last_word, 32'hA5C3_0F81);

        clear_counts();
        send_word(32'h8000_0001, 0);
        check(last_word == 32'h8000_0001, "R2 first bit in MSB", last_word, 32'h8000_0001);

        clear_counts();
        send_word(32'h1234_5678, 1);
        check(n_valid == 1 && last_word == 32'h1234_5678, "R3 data changes off the rising edge", last_word, 32'h1234_5678);

        clear_counts();
        send_word(32'hFFFF_0000, 2);
        check(n_err == 1 && n_valid == 0, "R4 missing gap error", n_err, 1);
        check(n_err == 1, "R7 no restart while sync held high", n_err, 1);
        check(word == 32'h1234_5678, "R4 word output unchanged", word, 32'h1234_5678);

        clear_counts();
        send_word(32'h0F0F_0F0F, 3);
        check(n_err == 1 && n_valid == 0, "R5 early sync drop", n_err, 1);

        clear_counts();
        send_word(32'h5555_AAAA, 4);
        check(n_err == 1 && n_valid == 0, "R6 sync high past 32 bits", n_err, 1);

        clear_counts();
        send_word(32'hDEAD_BEEF, 0);
        check(n_valid == 1 && last_word == 32'hDEAD_BEEF, "R7 recovery after error", last_word, 32'hDEAD_BEEF);

        // R8: clock stopped with sync low
        bclk = 1'b0; bsync = 1'b0;
        wait_n(WDL + 10);
        check(lost == 1'b1, "R8 clock lost", lost, 1);
        bclk = 1'b1;
        wait_n(5);
        check(lost == 1'b0, "R8 clears on edge", lost, 0);
        idle_bits(4);

        // Stall then 33rd edge: error and flag clear together
        clear_counts();
        send_word(32'hC001_D00D, 5);
        check(n_err == 1 && n_valid == 0, "R6 stalled overrun error", n_err, 1);
        check(lost == 1'b0, "R8 clear after resumed clock", lost, 0);

        clear_counts();
        send_word(32'h0000_0000, 0);
        check(n_valid == 1 && last_word == 32'h0, "R2 all-zero word", last_word, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule